// File: doc/BRIEF.md
# Dual-Address Compare-and-Swap Unit

This block performs one indivisible compare-and-swap across two unrelated memory locations. A requester presents two addresses, two expected values and two replacement values. The unit claims the memory bus with a lock signal. It reads both locations, compares each value it read with its expected value, and writes both replacement values only when both comparisons hold. When either comparison fails, it writes nothing and returns the two values it read, so the requester can retry with fresh expectations.

Condition flags report an unsigned subtraction of expected from read. The flags come from the first pair when that pair differs, and from the second pair otherwise. The lock stays asserted without a gap from the first read request until the last access of the operation has been acknowledged. Other bus agents therefore never see a half-updated pair.

Top module: `dcas_unit`

## Requirements
- R1: After reset, op_ready is 1 and mem_lock, mem_req, done and success are 0.
- R2: An operation is accepted on a clock edge where op_valid and op_ready are both 1. op_ready then stays 0 until the operation completes, and op_valid has no effect while op_ready is 0.
- R3: The unit first issues a read of op_addr_a and then a read of op_addr_b. Both reads are acknowledged before any write is requested.
- R4: If both read values equal their expected values, the unit writes op_new_a to op_addr_a and then op_new_b to op_addr_b, and reports success=1.
- R5: If either read value differs from its expected value, the unit issues no write and reports success=0. old_a and old_b carry the values read from op_addr_a and op_addr_b.
- R6: The flags are computed from read minus expected, taken over the unsigned data width. flag_z is 1 when the difference is zero, flag_n is the difference's most significant bit, and flag_c is 1 when a borrow occurs (read < expected). The first pair supplies the flags when it differs; otherwise the second pair does.
- R7: mem_req is 1 only while mem_lock is 1. mem_lock rises with the first read request and stays 1 until the last access is acknowledged. It falls in the cycle in which done is 1, and it is 0 whenever the unit is idle.
- R8: done is a single-cycle pulse per operation. success, old_a, old_b and the flags are valid in that cycle and hold until the next operation completes.
- R9: While mem_req is 1 and mem_ack is 0, mem_req, mem_we, mem_addr and mem_wdata hold their values.
- R10: When both addresses are equal, both reads return the same location's value. On success, the location is left holding op_new_b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_ready | output | 1 | Unit idle and able to accept |
| op_addr_a | input | AW | First location |
| op_addr_b | input | AW | Second location |
| op_cmp_a | input | W | Expected value at first location |
| op_cmp_b | input | W | Expected value at second location |
| op_new_a | input | W | Replacement for first location |
| op_new_b | input | W | Replacement for second location |
| done | output | 1 | One-cycle completion pulse |
| success | output | 1 | Both writes performed |
| old_a | output | W | Value read at first location |
| old_b | output | W | Value read at second location |
| flag_z | output | 1 | Zero flag of selected comparison |
| flag_n | output | 1 | Sign bit of selected difference |
| flag_c | output | 1 | Borrow of selected comparison |
| mem_lock | output | 1 | Bus lock held over the whole operation |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | AW | Access address |
| mem_wdata | output | W | Write data |
| mem_ack | input | 1 | Access accepted; read data valid this cycle |
| mem_rdata | input | W | Read data |

## Verification
The first read request appears in the cycle after acceptance. Each access then lasts until the edge at which mem_ack is sampled high. The comparison occupies one cycle after the second read is acknowledged. done follows one cycle after that comparison when the operation fails, or one cycle after the second write is acknowledged when it succeeds. Because the memory model inserts a varying number of wait cycles, the bench does not count a fixed latency. It waits for the done pulse and samples the results, the access log and the memory contents in the middle of that cycle, on the falling edge. Lock continuity and request-under-lock are checked on every falling edge between the first request and done.

// File: rtl/dcas_pkg.sv
package dcas_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD_A = 3'd1,
    ST_RD_B = 3'd2,
    ST_EVAL = 3'd3,
    ST_WR_A = 3'd4,
    ST_WR_B = 3'd5,
    ST_DONE = 3'd6
  } dcas_state_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
  } dcas_flags_t;

  localparam int unsigned NUM_LANES = 2;

endpackage

// File: rtl/dcas_lane.sv
module dcas_lane #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]       mem_val,
  input  logic [W-1:0]       cmp_val,
  output logic               eq,
  output dcas_pkg::dcas_flags_t flags
);
  import dcas_pkg::*;

  function automatic dcas_flags_t sub_flags(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] diff;
    dcas_flags_t f;
    diff = {1'b0, a} - {1'b0, b};
    f.c = diff[W];
    f.n = diff[W-1];
    f.z = (diff[W-1:0] == '0);
    return f;
  endfunction

  always_comb begin
    flags = sub_flags(mem_val, cmp_val);
    eq    = (mem_val == cmp_val);
  end

endmodule

// File: rtl/dcas_fsm.sv
module dcas_fsm (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic                  mem_ack,
  input  logic                  both_eq,
  output dcas_pkg::dcas_state_e state,
  output logic                  ev_accept,
  output logic                  ev_rd_a,
  output logic                  ev_rd_b,
  output logic                  ev_eval,
  output logic                  ev_wr_a,
  output logic                  ev_wr_b
);
  import dcas_pkg::*;

  dcas_state_e nxt;

  always_comb begin
    ev_accept = (state == ST_IDLE) && op_valid;
    ev_rd_a   = (state == ST_RD_A) && mem_ack;
    ev_rd_b   = (state == ST_RD_B) && mem_ack;
    ev_eval   = (state == ST_EVAL);
    ev_wr_a   = (state == ST_WR_A) && mem_ack;
    ev_wr_b   = (state == ST_WR_B) && mem_ack;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (ev_accept) nxt = ST_RD_A;
      ST_RD_A: if (ev_rd_a)   nxt = ST_RD_B;
      ST_RD_B: if (ev_rd_b)   nxt = ST_EVAL;
      ST_EVAL: nxt = both_eq ? ST_WR_A : ST_DONE;
      ST_WR_A: if (ev_wr_a)   nxt = ST_WR_B;
      ST_WR_B: if (ev_wr_b)   nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/dcas_busdrv.sv
module dcas_busdrv #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 32
) (
  input  dcas_pkg::dcas_state_e state,
  input  logic [AW-1:0]         addr_a,
  input  logic [AW-1:0]         addr_b,
  input  logic [W-1:0]          new_a,
  input  logic [W-1:0]          new_b,
  output logic                  mem_lock,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [AW-1:0]         mem_addr,
  output logic [W-1:0]          mem_wdata
);
  import dcas_pkg::*;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_lock  = 1'b0;
    unique case (state)
      ST_RD_A: begin mem_lock = 1'b1; mem_req = 1'b1; mem_addr = addr_a; end
      ST_RD_B: begin mem_lock = 1'b1; mem_req = 1'b1; mem_addr = addr_b; end
      ST_EVAL: begin mem_lock = 1'b1; end
      ST_WR_A: begin
        mem_lock = 1'b1; mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = addr_a; mem_wdata = new_a;
      end
      ST_WR_B: begin
        mem_lock = 1'b1; mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = addr_b; mem_wdata = new_b;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dcas_unit.sv
module dcas_unit #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [AW-1:0] op_addr_a,
  input  logic [AW-1:0] op_addr_b,
  input  logic [W-1:0]  op_cmp_a,
  input  logic [W-1:0]  op_cmp_b,
  input  logic [W-1:0]  op_new_a,
  input  logic [W-1:0]  op_new_b,
  output logic          done,
  output logic          success,
  output logic [W-1:0]  old_a,
  output logic [W-1:0]  old_b,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_c,
  output logic          mem_lock,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic          mem_ack,
  input  logic [W-1:0]  mem_rdata
);
  import dcas_pkg::*;

  localparam int unsigned NL = NUM_LANES;

  dcas_state_e state;
  logic ev_accept, ev_rd_a, ev_rd_b, ev_eval, ev_wr_a, ev_wr_b;

  logic [AW-1:0] addr_a_q, addr_b_q;
  logic [W-1:0]  cmp_q  [NL];
  logic [W-1:0]  new_a_q, new_b_q;
  logic [W-1:0]  rd_q   [NL];

  logic          lane_eq    [NL];
  dcas_flags_t   lane_flags [NL];
  logic          both_eq;
  dcas_flags_t   sel_flags;

  logic          success_q;
  logic [W-1:0]  old_a_q, old_b_q;
  dcas_flags_t   flags_q;

  dcas_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .mem_ack   (mem_ack),
    .both_eq   (both_eq),
    .state     (state),
    .ev_accept (ev_accept),
    .ev_rd_a   (ev_rd_a),
    .ev_rd_b   (ev_rd_b),
    .ev_eval   (ev_eval),
    .ev_wr_a   (ev_wr_a),
    .ev_wr_b   (ev_wr_b)
  );

  for (genvar g = 0; g < NL; g++) begin : g_lane
    dcas_lane #(.W(W)) u_lane (
      .mem_val (rd_q[g]),
      .cmp_val (cmp_q[g]),
      .eq      (lane_eq[g]),
      .flags   (lane_flags[g])
    );
  end

  always_comb begin
    both_eq   = lane_eq[0] && lane_eq[1];
    sel_flags = lane_eq[0] ? lane_flags[1] : lane_flags[0];
  end

  dcas_busdrv #(.W(W), .AW(AW)) u_bus (
    .state     (state),
    .addr_a    (addr_a_q),
    .addr_b    (addr_b_q),
    .new_a     (new_a_q),
    .new_b     (new_b_q),
    .mem_lock  (mem_lock),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_a_q <= '0;
      addr_b_q <= '0;
      cmp_q[0] <= '0;
      cmp_q[1] <= '0;
      new_a_q  <= '0;
      new_b_q  <= '0;
    end else if (ev_accept) begin
      addr_a_q <= op_addr_a;
      addr_b_q <= op_addr_b;
      cmp_q[0] <= op_cmp_a;
      cmp_q[1] <= op_cmp_b;
      new_a_q  <= op_new_a;
      new_b_q  <= op_new_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q[0] <= '0;
      rd_q[1] <= '0;
    end else begin
      if (ev_rd_a) rd_q[0] <= mem_rdata;
      if (ev_rd_b) rd_q[1] <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      success_q <= 1'b0;
      old_a_q   <= '0;
      old_b_q   <= '0;
      flags_q   <= '0;
    end else if (ev_eval) begin
      success_q <= both_eq;
      old_a_q   <= rd_q[0];
      old_b_q   <= rd_q[1];
      flags_q   <= sel_flags;
    end
  end

  always_comb begin
    op_ready = (state == ST_IDLE);
    done     = (state == ST_DONE);
    success  = success_q;
    old_a    = old_a_q;
    old_b    = old_b_q;
    flag_z   = flags_q.z;
    flag_n   = flags_q.n;
    flag_c   = flags_q.c;
  end

endmodule

// File: rtl/dcas_unit_chk.sv
module dcas_unit_chk #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_ready,
  input logic          done,
  input logic          success,
  input logic          mem_lock,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [W-1:0]  mem_wdata
);

  logic [1:0] rd_cnt, wr_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else if (done) begin
      rd_cnt <= '0;
      wr_cnt <= '0;
    end else if (mem_req && mem_ack) begin
      if (mem_we) wr_cnt <= wr_cnt + 2'd1;
      else        rd_cnt <= rd_cnt + 2'd1;
    end
  end

  AST_REQ_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_lock); // R7
  AST_LOCK_DROPS_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_lock) |-> done); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_lock |-> !op_ready); // R2
  AST_WRITE_AFTER_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (rd_cnt == 2'd2)); // R3
  AST_SUCCESS_TWO_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && success) |-> (wr_cnt == 2'd2)); // R4
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !success) |-> (wr_cnt == 2'd0)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && $stable(mem_wdata))); // R9

endmodule

bind dcas_unit dcas_unit_chk #(.W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_ready  (op_ready),
  .done      (done),
  .success   (success),
  .mem_lock  (mem_lock),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata)
);

// File: tb/dcas_unit_test.sv
`timescale 1ns/1ps
module dcas_unit_test;
  localparam int W  = 4;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          op_valid = 1'b0;
  logic          op_ready;
  logic [AW-1:0] op_addr_a = '0, op_addr_b = '0;
  logic [W-1:0]  op_cmp_a = '0, op_cmp_b = '0, op_new_a = '0, op_new_b = '0;
  logic          done, success, flag_z, flag_n, flag_c;
  logic [W-1:0]  old_a, old_b;
  logic          mem_lock, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [W-1:0]  mem_wdata;
  logic          mem_ack = 1'b0;
  logic [W-1:0]  mem_rdata = '0;

  dcas_unit #(.W(W), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_addr_a(op_addr_a), .op_addr_b(op_addr_b), .op_cmp_a(op_cmp_a),
    .op_cmp_b(op_cmp_b), .op_new_a(op_new_a), .op_new_b(op_new_b),
    .done(done), .success(success), .old_a(old_a), .old_b(old_b),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
    .mem_lock(mem_lock), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [W-1:0] mem [DEPTH];
  int  log_n;
  bit  log_we   [8];
  int  log_addr [8];
  int  log_data [8];
  int  lock_viol;
  bit  in_op;
  logic [7:0] lfsr = 8'h5A;
  int  wait_left = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory responder: grants at falling edge, design samples at next rising edge
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n) begin
      if (mem_req && !mem_lock) lock_viol++;
      if (in_op && log_n > 0 && !done && !mem_lock) lock_viol++;
      if (!in_op && mem_lock) lock_viol++;
      if (mem_req) begin
        if (wait_left > 0) wait_left--;
        else begin
          mem_ack <= 1'b1;
          if (log_n < 8) begin
            log_we[log_n]   = mem_we;
            log_addr[log_n] = int'(mem_addr);
            log_data[log_n] = int'(mem_wdata);
          end
          log_n++;
          if (mem_we) mem[mem_addr] = mem_wdata;
          else        mem_rdata <= mem[mem_addr];
          lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
          wait_left = int'(lfsr[1:0]) % 3;
        end
      end
    end
  end

  task automatic run_op(input int aa, input int ab, input int ca, input int cb,
                        input int ua, input int ub, input bit junk);
    int ma, mb, diff;
    bit ea, eb, succ, ez, en, ec;
    logic [W-1:0] fa, fb;
    ma = int'(mem[aa]); mb = int'(mem[ab]);
    ea = (ma == ca); eb = (mb == cb); succ = ea && eb;
    if (!ea) diff = ma - ca; else diff = mb - cb;
    ez = ((diff & 15) == 0); en = diff[3]; ec = (diff < 0);
    if (succ) begin
      fa = W'(ua); fb = W'(ub);
    end
    @(negedge clk);
    while (!op_ready) @(negedge clk);
    op_addr_a = AW'(aa); op_addr_b = AW'(ab);
    op_cmp_a = W'(ca); op_cmp_b = W'(cb); op_new_a = W'(ua); op_new_b = W'(ub);
    op_valid = 1'b1; log_n = 0; in_op = 1'b1;
    @(negedge clk);
    chk(op_ready == 1'b0, "R2 busy after accept", op_ready, 0);
    if (junk) begin
      // R2: requests while busy must be ignored
      op_addr_a = AW'(aa + 1); op_addr_b = AW'(ab + 3);
      op_cmp_a = ~W'(ca); op_new_a = W'(ua + 5); op_new_b = W'(ub + 7);
    end else op_valid = 1'b0;
    while (!done) @(negedge clk);
    op_valid = 1'b0;
    chk(success == succ, "R4/R5 success", success, succ);
    chk(old_a == W'(ma), "R5 old_a", old_a, ma);
    chk(old_b == W'(mb), "R5 old_b", old_b, mb);
    chk({flag_n, flag_z, flag_c} == {en, ez, ec}, "R6 flags n,z,c",
        {flag_n, flag_z, flag_c}, {en, ez, ec});
    chk(log_n == (succ ? 4 : 2), "R3/R4 access count", log_n, succ ? 4 : 2);
    chk(!log_we[0] && log_addr[0] == aa && !log_we[1] && log_addr[1] == ab,
        "R3 read order", log_addr[0] * 8 + log_addr[1], aa * 8 + ab);
    if (succ) begin
      chk(log_we[2] && log_addr[2] == aa && log_data[2] == ua && log_we[3]
          && log_addr[3] == ab && log_data[3] == ub, "R4 write order",
          log_data[2] * 16 + log_data[3], ua * 16 + ub);
      chk(mem[ab] == fb, "R4/R10 final second location", mem[ab], fb);
      if (aa != ab) chk(mem[aa] == fa, "R4 final first location", mem[aa], fa);
    end else begin
      chk(mem[aa] == W'(ma) && mem[ab] == W'(mb), "R5 memory untouched",
          mem[aa], ma);
    end
    chk(lock_viol == 0, "R7 lock continuity", lock_viol, 0);
    @(negedge clk);
    in_op = 1'b0;
    chk(done == 1'b0, "R8 done single pulse", done, 0);
    chk(success == succ && old_a == W'(ma), "R8 results held", success, succ);
    chk(mem_lock == 1'b0 && mem_req == 1'b0, "R7 idle lock low", mem_lock, 0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = W'(i * 3 + 1);
    lock_viol = 0; in_op = 1'b0; log_n = 0;
    repeat (3) @(negedge clk);
    chk(op_ready == 1'b1, "R1 reset ready", op_ready, 1);
    chk(mem_lock == 1'b0 && mem_req == 1'b0, "R1 reset bus idle", mem_lock, 0);
    chk(done == 1'b0 && success == 1'b0, "R1 reset done/success", done, 0);
    rst_n = 1'b1;
    // first pair swept, second pair matching
    for (int ma = 0; ma < 16; ma++)
      for (int ca = 0; ca < 16; ca++) begin
        mem[1] = W'(ma); mem[2] = 4'd5;
        run_op(1, 2, ca, 5, (ma + 7) & 15, 9, (ca == 3));
      end
    // first pair matching, second pair swept
    for (int mb = 0; mb < 16; mb++)
      for (int cb = 0; cb < 16; cb++) begin
        mem[4] = 4'd3; mem[6] = W'(mb);
        run_op(4, 6, 3, cb, 12, (mb + 1) & 15, 1'b0);
      end
    // every address pair, including equal addresses (R10)
    for (int aa = 0; aa < DEPTH; aa++)
      for (int ab = 0; ab < DEPTH; ab++) begin
        run_op(aa, ab, int'(mem[aa]), (aa == ab) ? int'(mem[aa]) : int'(mem[ab]),
               (aa + 2) & 15, (ab + 9) & 15, 1'b0);
      end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule